// File: doc/BRIEF.md
# Multichannel Ramp-Compare Conversion Back-End

This block is the digital half of a single-slope (Wilkinson) converter that serves many channels at once. A start pulse opens a conversion window. During that window one shared counter steps through a Gray-coded sequence while an external analog ramp rises. Each channel watches its own comparator bit. On the first rising edge of that bit, the channel stores the Gray value of that moment. A channel whose comparator never rises during the window reports the full-scale code.

When the window closes, every stored word is copied into a short shift segment. The segments are chained from the last channel down to channel 0, so together they form one long serial path. An external shift enable then moves the data out one bit per enabled cycle. Channel 0's word comes out first, most significant bit first. A done flag rises after the last bit has been shifted out.

The sequencing is handled by a state machine with five states: `ST_IDLE`, `ST_CONVERT`, `ST_LOAD`, `ST_SHIFT` and `ST_DONE`. Its transitions are:
- start-accepted: `ST_IDLE` or `ST_DONE` to `ST_CONVERT`
- ramp-complete: `ST_CONVERT` to `ST_LOAD`, when the count is at full scale
- words-loaded: `ST_LOAD` to `ST_SHIFT`, always after one cycle
- chain-empty: `ST_SHIFT` to `ST_DONE`, on the last enabled shift

Top module: `wk_backend`

## Requirements
- R1: The shared counter is W bits wide (default 10). It presents Gray code, `g = b ^ (b >> 1)`, so successive values differ in at most one bit. It is set to binary 0 on the clock edge that accepts a start.
- R2: A start is accepted only in `ST_IDLE` or `ST_DONE`. A start pulse during conversion or readout has no effect on the results.
- R3: Let E0 be the clock edge that accepts start. Each comparator bit passes through a two-flop synchronizer before rising-edge detection. A rising edge set up before edge E0+m is therefore stored as the Gray code of binary m+1.
- R4: Only the first rising edge of a channel's comparator in a window is stored. Later falls and rises are ignored until the next accepted start.
- R5: A channel with no detected rising edge in the window reports the full-scale code, Gray of binary 2^W-1 (10'h200 for W=10). This includes a comparator that was already high before the start.
- R6: In `ST_SHIFT`, each cycle with `shift_en` high advances the chain by one bit. Channel 0 comes out first, MSB first, then channel 1, and so on. With `shift_en` low, `sdata` holds its value, and `shift_en` has no effect outside `ST_SHIFT`.
- R7: `done` rises right after the NCH*W-th shift (320 by default) and stays high until the next accepted start. After reset, `done` and `sdata` are 0.
- R8: The window lasts 2^W counting cycles. The counter stops at full scale, and the words are loaded into the chain one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Ramp-start pulse, opens a conversion window |
| shift_en | input | 1 | Output-clock enable, one chain shift per high cycle |
| cmp | input | NCH | Comparator bits, one per channel, asynchronous |
| sdata | output | 1 | Serial data out of the channel chain |
| done | output | 1 | High after the whole chain has been shifted out |

## Verification
The bench builds the block with its default 32 channels and 10-bit counter. This brings the full 1024-step ramp, the clamp at full scale and the complete 320-bit chain within reach. The bench mixes seeded random crossing times with directed cases:
- crossings at the first and last reachable counts
- channels that never fire and channels already high before start
- glitching comparators
- a start pulse in mid-window
- `shift_en` held high during conversion
- idle gaps in readout

The bench decodes each serial word from Gray to binary and compares it with the crossing time it drove.

// File: rtl/wk_pkg.sv
package wk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONVERT,
        ST_LOAD,
        ST_SHIFT,
        ST_DONE
    } wk_state_e;

endpackage

// File: rtl/wk_ctrl.sv
// Shared control: sequencing FSM, Gray conversion counter, shift counter.
module wk_ctrl
    import wk_pkg::*;
#(
    parameter int W   = 10,
    parameter int NCH = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         shift_en,
    output wk_state_e    state,
    output logic [W-1:0] cnt_bin,
    output logic [W-1:0] cnt_gray,
    output logic         clr,
    output logic         arm,
    output logic         load,
    output logic         shift,
    output logic         done
);

    localparam int NBITS = NCH * W;
    localparam int SCW   = $clog2(NBITS + 1);
    localparam logic [W-1:0]   FULL     = '1;
    localparam logic [SCW-1:0] LAST_SH  = SCW'(NBITS - 1);

    wk_state_e      state_q, state_d;
    logic [W-1:0]   cnt_q;
    logic [SCW-1:0] sc_q;
    logic           accept;

    assign accept = start && (state_q == ST_IDLE || state_q == ST_DONE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_CONVERT;
            ST_CONVERT: if (cnt_q == FULL) state_d = ST_LOAD;
            ST_LOAD:    state_d = ST_SHIFT;
            ST_SHIFT:   if (shift_en && sc_q == LAST_SH) state_d = ST_DONE;
            ST_DONE:    if (start) state_d = ST_CONVERT;
            default:    state_d = ST_IDLE;
        endcase
    end

    // conversion counter, binary inside, Gray outside
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   cnt_q <= '0;
        else if (accept)                              cnt_q <= '0;
        else if (state_q == ST_CONVERT && cnt_q != FULL) cnt_q <= cnt_q + W'(1);
    end

    // readout bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  sc_q <= '0;
        else if (state_q == ST_LOAD) sc_q <= '0;
        else if (shift)              sc_q <= sc_q + SCW'(1);
    end

    // outputs
    always_comb begin
        state    = state_q;
        cnt_bin  = cnt_q;
        cnt_gray = cnt_q ^ (cnt_q >> 1);
        clr      = accept;
        arm      = (state_q == ST_CONVERT);
        load     = (state_q == ST_LOAD);
        shift    = (state_q == ST_SHIFT) && shift_en;
        done     = (state_q == ST_DONE);
    end

endmodule

// File: rtl/wk_chan_latch.sv
// Per-channel comparator synchronizer, edge detect and first-hit latch.
module wk_chan_latch #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmp_in,
    input  logic         clr,
    input  logic         arm,
    input  logic [W-1:0] gray,
    output logic [W-1:0] word,
    output logic         fired
);

    logic [2:0] sy_q;
    logic       rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= {sy_q[1:0], cmp_in};
    end

    assign rise = sy_q[1] & ~sy_q[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word  <= '0;
            fired <= 1'b0;
        end else if (clr) begin
            word  <= '0;
            fired <= 1'b0;
        end else if (arm && rise && !fired) begin
            word  <= gray;
            fired <= 1'b1;
        end
    end

endmodule

// File: rtl/wk_shift_seg.sv
// One channel's segment of the serial readout chain.
module wk_shift_seg #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] pdata,
    input  logic         sin,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= '0;
        else if (load)  q <= pdata;
        else if (shift) q <= {q[W-2:0], sin};
    end

endmodule

// File: rtl/wk_backend.sv
// Top: shared control, NCH capture channels, chained readout.
module wk_backend
    import wk_pkg::*;
#(
    parameter int NCH = 32,
    parameter int W   = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           shift_en,
    input  logic [NCH-1:0] cmp,
    output logic           sdata,
    output logic           done
);

    localparam logic [W-1:0] FS_BIN  = '1;
    localparam logic [W-1:0] FS_GRAY = FS_BIN ^ (FS_BIN >> 1);

    wk_state_e      state_w;
    logic [W-1:0]   cnt_bin, cnt_gray;
    logic           clr, arm, load, shift;
    logic [NCH-1:0] fired;
    logic [W-1:0]   word  [NCH];
    logic [W-1:0]   seg_q [NCH];
    logic [NCH-1:0] sin_w;

    wk_ctrl #(.W(W), .NCH(NCH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .shift_en (shift_en),
        .state    (state_w),
        .cnt_bin  (cnt_bin),
        .cnt_gray (cnt_gray),
        .clr      (clr),
        .arm      (arm),
        .load     (load),
        .shift    (shift),
        .done     (done)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic [W-1:0] pdata;

        wk_chan_latch #(.W(W)) u_lat (
            .clk    (clk),
            .rst_n  (rst_n),
            .cmp_in (cmp[i]),
            .clr    (clr),
            .arm    (arm),
            .gray   (cnt_gray),
            .word   (word[i]),
            .fired  (fired[i])
        );

        assign pdata = fired[i] ? word[i] : FS_GRAY;

        if (i == NCH - 1) begin : g_tail
            assign sin_w[i] = 1'b0;
        end else begin : g_link
            assign sin_w[i] = seg_q[i+1][W-1];
        end

        wk_shift_seg #(.W(W)) u_seg (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (load),
            .shift (shift),
            .pdata (pdata),
            .sin   (sin_w[i]),
            .q     (seg_q[i])
        );
    end

    assign sdata = seg_q[0][W-1];

endmodule

// File: rtl/wk_backend_chk.sv
module wk_backend_chk
    import wk_pkg::*;
#(
    parameter int NCH = 32,
    parameter int W   = 10
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           shift_en,
    input logic           sdata,
    input logic           done,
    input wk_state_e      state,
    input logic [W-1:0]   cnt_bin,
    input logic [W-1:0]   cnt_gray,
    input logic [NCH-1:0] fired
);

    logic accept;
    assign accept = start && (state == ST_IDLE || state == ST_DONE);

    AST_GRAY_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n) // R1
        (state == ST_CONVERT && $past(state) == ST_CONVERT) |-> $countones(cnt_gray ^ $past(cnt_gray)) <= 1);

    AST_START_ZEROES: assert property (@(posedge clk) disable iff (!rst_n) // R1
        accept |=> (state == ST_CONVERT && cnt_bin == '0));

    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n) // R2
        (state == ST_SHIFT && start && !shift_en) |=> (state == ST_SHIFT));

    AST_FIRST_HIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) // R4
        !accept |=> ((fired & $past(fired)) == $past(fired)));

    AST_FULL_AT_LOAD: assert property (@(posedge clk) disable iff (!rst_n) // R8
        (state == ST_LOAD) |-> (cnt_bin == '1));

    AST_IDLE_SHIFT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) // R6
        (state == ST_SHIFT && !shift_en) |=> $stable(sdata));

    AST_DONE_STICKS: assert property (@(posedge clk) disable iff (!rst_n) // R7
        (done && !start) |=> done);

endmodule

bind wk_backend wk_backend_chk #(.NCH(NCH), .W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .shift_en (shift_en),
    .sdata    (sdata),
    .done     (done),
    .state    (state_w),
    .cnt_bin  (cnt_bin),
    .cnt_gray (cnt_gray),
    .fired    (fired)
);

// File: tb/wk_backend_tb.sv
module wk_backend_tb;

    localparam int CLK_NS = 10;
    localparam int NCH    = 32;
    localparam int W      = 10;
    localparam int NBITS  = NCH * W;
    localparam int FS     = (1 << W) - 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic           shift_en = 1'b0;
    logic [NCH-1:0] cmp = '0;
    logic           sdata, done;

    int n_chk  = 0;
    int n_fail = 0;
    bit summary_done = 1'b0;

    int t_a   [NCH];
    bit pre_a [NCH];
    bit gl_a  [NCH];

    always #(CLK_NS / 2) clk = ~clk;

    wk_backend #(.NCH(NCH), .W(W)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .shift_en (shift_en),
        .cmp      (cmp),
        .sdata    (sdata),
        .done     (done)
    );

    function automatic int b2g(input int b);
        return b ^ (b >> 1);
    endfunction

    function automatic int g2b(input int g);
        int b = 0;
        for (int k = W - 1; k >= 0; k--) begin
            b[k] = g[k] ^ ((k == W - 1) ? 1'b0 : b[k+1]);
        end
        return b;
    endfunction

    function automatic bit drive_cmp(input int t, input bit g, input int n);
        bit v;
        if (t < 0) return 1'b0;
        v = (n >= t);
        if (g && n >= t + 3 && n < t + 10) v = 1'b0;
        return v;
    endfunction

    function automatic int exp_bin(input int i);
        int e;
        if (pre_a[i] || t_a[i] < 0) return FS;
        e = t_a[i] + 2;
        return (e > FS) ? FS : e;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        end
    endtask

    task automatic run_conv(input bit mid_start, input bit en_during, input bit gaps);
        logic [W-1:0] obs [NCH];
        logic prev;
        string tag;
        cmp = '0;
        repeat (5) @(negedge clk);
        for (int i = 0; i < NCH; i++) cmp[i] = pre_a[i];
        repeat (4) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int n = 0; n < 1030; n++) begin
            for (int i = 0; i < NCH; i++)
                if (!pre_a[i]) cmp[i] = drive_cmp(t_a[i], gl_a[i], n);
            start    = mid_start && (n == 500);   // R2: must be ignored
            shift_en = en_during && (n < 1020);   // R6: no effect before readout
            @(negedge clk);
        end
        start = 1'b0;
        shift_en = 1'b0;
        chk(done == 1'b0, "R7 done low before readout", done, 0);
        for (int b = 0; b < NBITS; b++) begin
            obs[b / W][W - 1 - (b % W)] = sdata;
            if (gaps && ($urandom % 4 == 0)) begin
                prev = sdata;
                @(negedge clk);
                chk(sdata == prev, "R6 hold without shift_en", sdata, prev);
            end
            if (b == NBITS - 1) chk(done == 1'b0, "R7 done before last shift", done, 0);
            shift_en = 1'b1;
            @(negedge clk);
            shift_en = 1'b0;
        end
        chk(done == 1'b1, "R7 done after last shift", done, 1);
        for (int i = 0; i < NCH; i++) begin
            if (pre_a[i] || t_a[i] < 0) begin
                tag = "R5 full scale";
                chk(obs[i] == W'(b2g(FS)), "R5 full-scale Gray code", int'(obs[i]), b2g(FS));
            end else if (gl_a[i]) tag = "R4 first edge only";
            else tag = "R3 capture time";
            chk(g2b(int'(obs[i])) == exp_bin(i), tag, g2b(int'(obs[i])), exp_bin(i));
        end
        repeat (3) @(negedge clk);
        chk(done == 1'b1, "R7 done persists", done, 1);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R7 reset done", done, 0);
        chk(sdata == 1'b0, "R7 reset sdata", sdata, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0, "R7 idle done", done, 0);

        // run 0: directed spread, first count, one silent channel
        for (int i = 0; i < NCH; i++) begin
            t_a[i] = i * 31; pre_a[i] = 1'b0; gl_a[i] = 1'b0;
        end
        t_a[5] = -1;
        run_conv(1'b0, 1'b0, 1'b0);

        // run 1: random, with boundary crossing times
        for (int i = 0; i < NCH; i++) begin
            t_a[i] = int'($urandom % 1022); pre_a[i] = 1'b0; gl_a[i] = 1'b0;
        end
        t_a[1] = 0;
        t_a[NCH-1] = 1021;
        run_conv(1'b0, 1'b0, 1'b1);

        // run 2: glitches, start in mid-window, shift_en during conversion
        for (int i = 0; i < NCH; i++) begin
            t_a[i] = int'($urandom % 1000); pre_a[i] = 1'b0; gl_a[i] = (i % 2 == 0);
        end
        run_conv(1'b1, 1'b1, 1'b1);

        // run 3: random, already-high and silent channels
        for (int i = 0; i < NCH; i++) begin
            t_a[i] = (i % 7 == 3) ? -1 : int'($urandom % 1022);
            pre_a[i] = (i % 3 == 0);
            gl_a[i] = 1'b0;
        end
        run_conv(1'b0, 1'b0, 1'b1);

        summary();
        $finish;
    end

    initial begin
        #(CLK_NS * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        summary();
        $finish;
    end

endmodule